// File: doc/BRIEF.md
# Mode-Selectable Two-Way Registered Transceiver

This block carries a byte-wide word in two directions between a split A side and a shared B side. The A side has a separate input vector and a tri-stated output vector. The B side is an open-drain style bus. The block produces a per-bit pull-down request, and the resolved bus level is read back on a sense input. Each direction has its own storage element. A two-bit mode chooses whether that element is a plain pass-through, an edge-triggered register or a level-sensitive transparent store. Every element output is the bitwise inverse of the value the element holds or passes.

Each direction has a strobe that acts as its capture clock or its transparency enable. The strobes are synchronous inputs sampled by the block clock. Register mode captures on a clock edge where the strobe is high and was low at the previous edge. A loopback select feeds the B-to-A element from the A-to-B element's pre-inversion value instead of from the bus. This lets a host read back what it is about to put on the backplane. The two output enables only gate the pins. The storage behind them keeps working while the pins are off.

Top module: `bidir_mode_transceiver`

## Requirements
- R1: Mode codes per direction are: 2'b00 pass-through, 2'b01 edge register, 2'b10 and 2'b11 both transparent store.
- R2: In pass-through mode an element's output is the bitwise inverse of its input in the same cycle, with no clock edge needed.
- R3: In edge-register mode the element loads its input at a clock edge where its strobe is sampled 1 after being 0 at the previous edge. After that edge the output is the inverse of the loaded word. At every other edge, including while the strobe stays high, it holds.
- R4: In transparent mode, while the strobe is 1 the output is the inverse of the live input and the store loads at each clock edge. While the strobe is 0 the output is the inverse of the word loaded at the last edge with the strobe at 1.
- R5: With loopback 0 the B-to-A element's input is b_sense. With loopback 1 it is the A-to-B element's value before inversion.
- R6: a_out is driven with the B-to-A element output only while a_oe is 1, and is all high-impedance otherwise.
- R7: b_drive_low bit i is 1 exactly when b_oe is 1, b_oe_n is 0 and bit i of the A-to-B element output is 0. For every other enable combination the vector is all 0, and with no other driver the bus senses all 1.
- R8: Both elements load and hold exactly as in R3 and R4 while a_oe is 0 and the B drive is off.
- R9: A synchronous reset clears both stores and the strobe history to 0. After reset, register and idle transparent modes output all 1.
- R10: A mode change acts on the outputs in the same cycle, and the stored word is kept across mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | DATA_W | A side input word, feeds the A-to-B element |
| a_out | output | DATA_W | A side output word, tri-stated by a_oe |
| a_oe | input | 1 | A output enable, active high |
| b_sense | input | DATA_W | Resolved B bus level (wired-AND with pull-up) |
| b_drive_low | output | DATA_W | Per-bit pull-down request onto the B bus |
| b_oe | input | 1 | B drive enable, active high |
| b_oe_n | input | 1 | B drive enable, active low; both must agree to drive |
| ab_mode | input | 2 | A-to-B element mode |
| ab_strobe | input | 1 | A-to-B capture strobe or transparency enable |
| ba_mode | input | 2 | B-to-A element mode |
| ba_strobe | input | 1 | B-to-A capture strobe or transparency enable |
| loopback | input | 1 | Selects the B-to-A element's input source |

## Verification
Pass-through, transparent, enable and loopback results are combinational and due in the same cycle as the stimulus. The bench changes inputs on the falling clock edge and compares one nanosecond later, before the next rising edge. Register loads and transparent-store holds appear only after the rising edge that samples the strobe. The behavioural reference updates its stores on that same rising edge, so the comparison made after the following falling edge expects the new word exactly one edge after the strobe was set up. Every cycle is compared, so a capture one edge early or late shows up as a mismatch.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;

   typedef enum logic [1:0] {
      KIND_PASS  = 2'd0,
      KIND_EDGE  = 2'd1,
      KIND_LATCH = 2'd2
   } elem_kind_e;

   // R1: high bit set selects the transparent store regardless of the low bit
   function automatic elem_kind_e decode_mode(input logic [1:0] m);
      if (m[1]) return KIND_LATCH;
      if (m[0]) return KIND_EDGE;
      return KIND_PASS;
   endfunction

endpackage

// File: rtl/txr_element.sv
`timescale 1ns/1ps
module txr_element
   import txr_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] STORE_INIT = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode,
   input  logic              strobe,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] pre_out,
   output logic [DATA_W-1:0] dout
);

   if (DATA_W < 1) begin : g_bad_width
      $error("txr_element: DATA_W must be at least 1");
   end

   elem_kind_e        kind;
   logic              strobe_q;
   logic              rise;
   logic [DATA_W-1:0] held;

   assign kind = decode_mode(mode);
   assign rise = strobe & ~strobe_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         held     <= STORE_INIT;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= strobe;
         unique case (kind)
            KIND_EDGE:  if (rise)   held <= din;
            KIND_LATCH: if (strobe) held <= din;
            default:    held <= held;
         endcase
      end
   end

   always_comb begin
      unique case (kind)
         KIND_EDGE:  pre_out = held;
         KIND_LATCH: pre_out = strobe ? din : held;
         default:    pre_out = din;
      endcase
   end

   assign dout = ~pre_out;

   // R3: a detected rising strobe loads the input word
   assert_edge_capture_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(kind == KIND_EDGE && rise) && kind == KIND_EDGE)
         |-> (pre_out == $past(din)));

   // R3: without a rising strobe the register output is steady
   assert_edge_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && kind == KIND_EDGE && $past(kind == KIND_EDGE) && !$past(rise))
         |-> $stable(pre_out));

   // R4: closed transparent store holds its word
   assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && kind == KIND_LATCH && $past(kind == KIND_LATCH)
         && !$past(strobe) && !strobe)
         |-> $stable(pre_out));

endmodule

// File: rtl/txr_port_stage.sv
`timescale 1ns/1ps
module txr_port_stage #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              a_oe,
   input  logic              b_oe,
   input  logic              b_oe_n,
   input  logic [DATA_W-1:0] ab_line,
   input  logic [DATA_W-1:0] ba_line,
   output logic [DATA_W-1:0] a_out,
   output logic [DATA_W-1:0] b_drive_low
);

   if (DATA_W < 1) begin : g_bad_width
      $error("txr_port_stage: DATA_W must be at least 1");
   end

   logic b_on;
   assign b_on = b_oe & ~b_oe_n;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      assign b_drive_low[g] = b_on & ~ab_line[g];
      assign a_out[g]       = a_oe ? ba_line[g] : 1'bz;
   end

   // R7: any enable pair other than (1,0) releases every bus bit
   assert_b_release_R7: assert property (@(posedge clk) disable iff (rst)
      !(b_oe && !b_oe_n) |-> (b_drive_low == '0));

endmodule

// File: rtl/bidir_mode_transceiver.sv
`timescale 1ns/1ps
module bidir_mode_transceiver
   import txr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   input  logic              a_oe,
   input  logic [DATA_W-1:0] b_sense,
   output logic [DATA_W-1:0] b_drive_low,
   input  logic              b_oe,
   input  logic              b_oe_n,
   input  logic [1:0]        ab_mode,
   input  logic              ab_strobe,
   input  logic [1:0]        ba_mode,
   input  logic              ba_strobe,
   input  logic              loopback
);

   if (DATA_W < 1) begin : g_bad_width
      $error("bidir_mode_transceiver: DATA_W must be at least 1");
   end

   localparam logic [DATA_W-1:0] STORE_INIT = '0;

   logic [DATA_W-1:0] ab_pre, ab_line;
   logic [DATA_W-1:0] ba_pre, ba_line;
   logic [DATA_W-1:0] ba_src;

   txr_element #(.DATA_W(DATA_W), .STORE_INIT(STORE_INIT)) u_elem_ab (
      .clk     (clk),
      .rst     (rst),
      .mode    (ab_mode),
      .strobe  (ab_strobe),
      .din     (a_in),
      .pre_out (ab_pre),
      .dout    (ab_line)
   );

   assign ba_src = loopback ? ab_pre : b_sense;

   txr_element #(.DATA_W(DATA_W), .STORE_INIT(STORE_INIT)) u_elem_ba (
      .clk     (clk),
      .rst     (rst),
      .mode    (ba_mode),
      .strobe  (ba_strobe),
      .din     (ba_src),
      .pre_out (ba_pre),
      .dout    (ba_line)
   );

   txr_port_stage #(.DATA_W(DATA_W)) u_ports (
      .clk         (clk),
      .rst         (rst),
      .a_oe        (a_oe),
      .b_oe        (b_oe),
      .b_oe_n      (b_oe_n),
      .ab_line     (ab_line),
      .ba_line     (ba_line),
      .a_out       (a_out),
      .b_drive_low (b_drive_low)
   );

   // R5: looped back through a pass-through B-to-A element, the A pins
   // show the same word the A-to-B element presents toward the bus
   assert_loopback_path_R5: assert property (@(posedge clk) disable iff (rst)
      (loopback && a_oe && decode_mode(ba_mode) == KIND_PASS) |-> (a_out == ab_line));

endmodule

// File: tb/bidir_mode_transceiver_bench.sv
`timescale 1ns/1ps
module bidir_mode_transceiver_bench;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] a_in, ext_low;
   logic         a_oe, b_oe, b_oe_n, loopback;
   logic [1:0]   ab_mode, ba_mode;
   logic         ab_strobe, ba_strobe;
   wire  [W-1:0] a_out, b_drive_low, b_sense;

   int checks = 0;
   int errors = 0;

   // model state
   logic [W-1:0] m_ab_q, m_ba_q;
   logic         m_ab_prev, m_ba_prev;

   always #2 clk = ~clk;

   assign b_sense = ~(b_drive_low | ext_low);

   bidir_mode_transceiver #(.DATA_W(W)) u_bidir_mode_transceiver (
      .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_sense(b_sense), .b_drive_low(b_drive_low), .b_oe(b_oe), .b_oe_n(b_oe_n),
      .ab_mode(ab_mode), .ab_strobe(ab_strobe), .ba_mode(ba_mode),
      .ba_strobe(ba_strobe), .loopback(loopback)
   );

   function automatic logic [W-1:0] ref_pre(input logic [1:0] md, input logic st,
                                            input logic [W-1:0] d, input logic [W-1:0] q);
      if (md == 2'b00) return d;
      if (md == 2'b01) return q;
      return st ? d : q;
   endfunction

   task automatic eval_model(output logic [W-1:0] p_ab, output logic [W-1:0] p_ba,
                             output logic [W-1:0] drv, output logic [W-1:0] ba_in);
      logic [W-1:0] sense;
      p_ab  = ref_pre(ab_mode, ab_strobe, a_in, m_ab_q);
      drv   = (b_oe && !b_oe_n) ? p_ab : '0;
      sense = ~(drv | ext_low);
      ba_in = loopback ? p_ab : sense;
      p_ba  = ref_pre(ba_mode, ba_strobe, ba_in, m_ba_q);
   endtask

   always @(posedge clk) begin
      logic [W-1:0] p_ab, p_ba, drv, ba_in;
      eval_model(p_ab, p_ba, drv, ba_in);
      if (rst) begin
         m_ab_q = '0; m_ba_q = '0; m_ab_prev = 1'b0; m_ba_prev = 1'b0;
      end else begin
         if ((ab_mode == 2'b01 && ab_strobe && !m_ab_prev) || (ab_mode[1] && ab_strobe))
            m_ab_q = a_in;
         if ((ba_mode == 2'b01 && ba_strobe && !m_ba_prev) || (ba_mode[1] && ba_strobe))
            m_ba_q = ba_in;
         m_ab_prev = ab_strobe;
         m_ba_prev = ba_strobe;
      end
   end

   task automatic chk(input string tag);
      logic [W-1:0] p_ab, p_ba, drv, ba_in, exp_a;
      #1;
      eval_model(p_ab, p_ba, drv, ba_in);
      exp_a = a_oe ? ~p_ba : {W{1'bz}};
      checks++;
      if (a_out !== exp_a) begin
         errors++;
         $display("FAIL %s a_out actual=%b expected=%b", tag, a_out, exp_a);
      end
      checks++;
      if (b_drive_low !== drv) begin
         errors++;
         $display("FAIL %s b_drive_low actual=%b expected=%b", tag, b_drive_low, drv);
      end
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst = 1'b1; a_in = '0; ext_low = '0; a_oe = 1'b1; b_oe = 1'b1; b_oe_n = 1'b0;
      loopback = 1'b0; ab_mode = 2'b01; ba_mode = 2'b01; ab_strobe = 1'b0; ba_strobe = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R9: cleared stores give all-ones outputs
      chk("R9");
      ab_mode = 2'b10; ba_mode = 2'b11; chk("R9");

      // R2: pass-through both ways through the bus
      ab_mode = 2'b00; ba_mode = 2'b00;
      foreach (a_in[i]) ;
      a_in = 8'h00; chk("R2");
      a_in = 8'hFF; chk("R2");
      a_in = 8'hA5; chk("R2");
      a_in = 8'h3C; chk("R2");

      // R7: all four enable combinations
      a_in = 8'h5A;
      b_oe = 1'b0; b_oe_n = 1'b0; chk("R7");
      b_oe = 1'b0; b_oe_n = 1'b1; chk("R7");
      b_oe = 1'b1; b_oe_n = 1'b1; chk("R7");
      b_oe = 1'b1; b_oe_n = 1'b0; chk("R7");
      // R5: bus source with another driver pulling low
      b_oe = 1'b0; ext_low = 8'h81; chk("R5");
      b_oe = 1'b1; chk("R5");
      ext_low = '0;

      // R3: edge register in A-to-B
      ab_mode = 2'b01; a_in = 8'hC3; chk("R3");
      ab_strobe = 1'b1; chk("R3");
      a_in = 8'h0F; chk("R3");
      chk("R3");
      ab_strobe = 1'b0; chk("R3");
      ab_strobe = 1'b1; chk("R3");
      chk("R3");
      ab_strobe = 1'b0;
      // R3: edge register in B-to-A
      ab_mode = 2'b00; ba_mode = 2'b01; a_in = 8'h96; chk("R3");
      ba_strobe = 1'b1; chk("R3");
      a_in = 8'h11; chk("R3");
      ba_strobe = 1'b0; chk("R3");

      // R4 / R1: transparent store, both codes
      ab_mode = 2'b10; ab_strobe = 1'b1; a_in = 8'h24; chk("R4");
      a_in = 8'h42; chk("R4");
      ab_strobe = 1'b0; a_in = 8'hE7; chk("R4");
      a_in = 8'h18; chk("R4");
      ab_mode = 2'b11; chk("R1");
      ab_strobe = 1'b1; chk("R1");
      ab_strobe = 1'b0; a_in = 8'h00; chk("R4");
      ba_mode = 2'b10; ba_strobe = 1'b1; chk("R4");
      ba_strobe = 1'b0; a_in = 8'hFF; chk("R4");

      // R8: stores keep working with both outputs off
      a_oe = 1'b0; b_oe = 1'b0; loopback = 1'b1;
      ab_mode = 2'b10; ba_mode = 2'b01;
      a_in = 8'h6D; ab_strobe = 1'b1; ba_strobe = 1'b1; chk("R8");
      ab_strobe = 1'b0; ba_strobe = 1'b0; a_in = 8'h00; chk("R8");
      a_oe = 1'b1; b_oe = 1'b1; chk("R8");

      // R5: loopback with register, store and pass-through feeding A
      ba_mode = 2'b00; ab_mode = 2'b01; a_in = 8'hB2; chk("R5");
      ab_strobe = 1'b1; chk("R5");
      ab_strobe = 1'b0; ext_low = 8'hFF; chk("R5");
      loopback = 1'b0; chk("R5");
      ext_low = '0; loopback = 1'b1;

      // R10: mode changes act at once and keep the store
      ab_mode = 2'b00; a_in = 8'h5F; chk("R10");
      ab_mode = 2'b01; chk("R10");
      ab_mode = 2'b10; chk("R10");
      ab_mode = 2'b01; chk("R10");

      // R6: A pins released
      a_oe = 1'b0; chk("R6");
      a_in = 8'h77; ab_mode = 2'b00; chk("R6");
      a_oe = 1'b1; chk("R6");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule